// File: doc/BRIEF.md
# Streaming Constant-Coefficient Dot Product Unit

This block computes the dot product of two integer vectors held in two separate memories. One vector holds fixed signed coefficients stored in the instruction ROM. The other holds signed variables stored in the data RAM. A single start command carries both base addresses and the vector length. The unit then reads both memories in the same cycle, one element per cycle, and folds each product into a wide accumulator. At full throughput it adds one multiply-add term per memory cycle.

Both memories have a one-cycle synchronous read. The unit raises a read strobe with an address, and the word it asked for is on the data input in the following cycle. When the last term has been added, a one-cycle done pulse marks the final sum. The sum stays on the result output until the next accepted start. A program steps through the vectors with its hardware loop and issues one start per dot product. It needs no branch instructions for this.

Top module: `dotp_engine`

## Requirements
- R1: After reset, busy, done and both read strobes are low and the result reads 0.
- R2: A start seen while busy is low is accepted. Busy is high from the cycle after acceptance until the cycle in which done is high, and it is low in that done cycle.
- R3: For a length N greater than 0, both read strobes are high together in the N consecutive cycles that follow acceptance. In read cycle i (counting from 0), the coefficient address is coefficient base + i and the variable address is variable base + i, each wrapping modulo 2^AW.
- R4: The result is the signed sum over i of coefficient[i] times variable[i]. The data words are 16-bit two's complement values and the result is a 40-bit two's complement value.
- R5: For N greater than 0, done is high for exactly one cycle, N+1 clock edges after the accepting edge. The result holds its value after done until the next accepted start.
- R6: A start with length 0 raises no read strobe, returns a result of 0 and raises done one edge after the accepting edge.
- R7: A start seen while busy is high is ignored. The running operation keeps its addresses, its timing and its result.
- R8: A start in the done cycle is accepted and clears the accumulator, so back-to-back operations need no idle cycle between them.
- R9: 256 terms of (-32768)*(-32768) give a result of 2^38 with no overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start command |
| cbase_i | input | AW | Coefficient base address in the instruction ROM |
| vbase_i | input | AW | Variable base address in the data RAM |
| len_i | input | LW | Number of terms (0 to 256) |
| coef_rd_o | output | 1 | Coefficient read strobe |
| coef_addr_o | output | AW | Coefficient read address |
| coef_data_i | input | DW | Coefficient word, one cycle after the strobe |
| var_rd_o | output | 1 | Variable read strobe |
| var_addr_o | output | AW | Variable read address |
| var_data_i | input | DW | Variable word, one cycle after the strobe |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle pulse when the result is final |
| result_o | output | ACCW | Accumulated dot product |

## Verification
The hardest case to reach is a start that lands in the one cycle where done is high and busy has just dropped. The accumulator must be cleared there while the previous sum is still being reported. The driver task waits only until busy is low before it raises start, so queuing a second operation right behind the first lands the start in that done cycle. A start during a long run, with a different length and different bases, checks that the unit ignores commands while it is busy. A wrapping base address and a full run of the most negative values at length 256 cover the address and accumulator edges.

// File: rtl/dotp_pkg.sv
package dotp_pkg;

    // Control pipeline state of the engine
    typedef struct packed {
        logic busy;   // operation in flight
        logic vld;    // read data valid this cycle
        logic last;   // valid data is the final term
        logic zero;   // zero-length command pending
        logic done;   // result final
    } ctl_t;

endpackage

// File: rtl/dotp_addr_gen.sv
module dotp_addr_gen #(
    parameter int AW = 10,
    parameter int LW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [AW-1:0] cbase_i,
    input  logic [AW-1:0] vbase_i,
    input  logic [LW-1:0] len_i,
    output logic          rd_o,
    output logic          last_o,
    output logic [AW-1:0] caddr_o,
    output logic [AW-1:0] vaddr_o
);

    typedef struct packed {
        logic          active;
        logic [LW-1:0] left;
        logic [AW-1:0] caddr;
        logic [AW-1:0] vaddr;
    } ag_t;

    ag_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.caddr  = cbase_i;
            st_d.vaddr  = vbase_i;
            st_d.left   = len_i;
            st_d.active = (len_i != '0);
        end else if (st_q.active) begin
            st_d.caddr = st_q.caddr + 1'b1;
            st_d.vaddr = st_q.vaddr + 1'b1;
            st_d.left  = st_q.left - 1'b1;
            if (st_q.left == LW'(1)) begin
                st_d.active = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_o    = st_q.active;
    assign last_o  = st_q.active && (st_q.left == LW'(1));
    assign caddr_o = st_q.caddr;
    assign vaddr_o = st_q.vaddr;

endmodule

// File: rtl/dotp_mac.sv
module dotp_mac #(
    parameter int DW   = 16,
    parameter int ACCW = 40
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr_i,
    input  logic            en_i,
    input  logic [DW-1:0]   coef_i,
    input  logic [DW-1:0]   var_i,
    output logic [ACCW-1:0] acc_o
);

    localparam int PW = 2 * DW;

    logic signed [PW-1:0]   prod;
    logic signed [ACCW-1:0] prod_ext;
    logic signed [ACCW-1:0] acc_d, acc_q;

    assign prod     = $signed(coef_i) * $signed(var_i);
    assign prod_ext = {{(ACCW-PW){prod[PW-1]}}, prod};

    always_comb begin
        acc_d = acc_q;
        if (clr_i) begin
            acc_d = '0;
        end else if (en_i) begin
            acc_d = acc_q + prod_ext;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_d;
        end
    end

    assign acc_o = acc_q;

endmodule

// File: rtl/dotp_engine.sv
module dotp_engine
    import dotp_pkg::*;
#(
    parameter int DW     = 16,
    parameter int AW     = 10,
    parameter int MAXLEN = 256,
    parameter int ACCW   = 40,
    parameter int LW     = $clog2(MAXLEN + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic [AW-1:0]   cbase_i,
    input  logic [AW-1:0]   vbase_i,
    input  logic [LW-1:0]   len_i,
    output logic            coef_rd_o,
    output logic [AW-1:0]   coef_addr_o,
    input  logic [DW-1:0]   coef_data_i,
    output logic            var_rd_o,
    output logic [AW-1:0]   var_addr_o,
    input  logic [DW-1:0]   var_data_i,
    output logic            busy_o,
    output logic            done_o,
    output logic [ACCW-1:0] result_o
);

    ctl_t ctl_d, ctl_q;
    logic accept;
    logic rd;
    logic last;

    assign accept = start_i && !ctl_q.busy;

    dotp_addr_gen #(.AW(AW), .LW(LW)) u_ag (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (accept),
        .cbase_i (cbase_i),
        .vbase_i (vbase_i),
        .len_i   (len_i),
        .rd_o    (rd),
        .last_o  (last),
        .caddr_o (coef_addr_o),
        .vaddr_o (var_addr_o)
    );

    dotp_mac #(.DW(DW), .ACCW(ACCW)) u_mac (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (accept),
        .en_i   (ctl_q.vld),
        .coef_i (coef_data_i),
        .var_i  (var_data_i),
        .acc_o  (result_o)
    );

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.vld  = rd;
        ctl_d.last = rd && last;
        ctl_d.zero = accept && (len_i == '0);
        ctl_d.done = (ctl_q.vld && ctl_q.last) || ctl_q.zero;
        if (accept) begin
            ctl_d.busy = 1'b1;
        end else if (ctl_d.done) begin
            ctl_d.busy = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign coef_rd_o = rd;
    assign var_rd_o  = rd;
    assign busy_o    = ctl_q.busy;
    assign done_o    = ctl_q.done;

endmodule

// File: rtl/dotp_engine_chk.sv
module dotp_engine_chk #(
    parameter int AW = 10,
    parameter int LW = 9
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start_i,
    input logic [LW-1:0] len_i,
    input logic          coef_rd_o,
    input logic          var_rd_o,
    input logic [AW-1:0] coef_addr_o,
    input logic [AW-1:0] var_addr_o,
    input logic          busy_o,
    input logic          done_o
);

    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R2
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    // R2
    busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);

    // R3
    rd_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        coef_rd_o |-> (busy_o && var_rd_o));

    // R3
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (coef_rd_o && $past(coef_rd_o)) |->
        (coef_addr_o == $past(coef_addr_o) + 1'b1) &&
        (var_addr_o == $past(var_addr_o) + 1'b1));

    // R6
    zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && len_i == '0) |=> !coef_rd_o);

endmodule

bind dotp_engine dotp_engine_chk #(.AW(AW), .LW(LW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .len_i       (len_i),
    .coef_rd_o   (coef_rd_o),
    .var_rd_o    (var_rd_o),
    .coef_addr_o (coef_addr_o),
    .var_addr_o  (var_addr_o),
    .busy_o      (busy_o),
    .done_o      (done_o)
);

// File: tb/sim_dotp_engine.sv
module sim_dotp_engine;

    localparam int DW   = 16;
    localparam int AW   = 10;
    localparam int ACCW = 40;
    localparam int LW   = 9;
    localparam int MSZ  = 1 << AW;

    typedef struct {
        longint sum;
        longint cyc;
        int     n;
        string  tag;
    } exp_t;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start_i = 1'b0;
    logic [AW-1:0]   cbase_i = '0;
    logic [AW-1:0]   vbase_i = '0;
    logic [LW-1:0]   len_i = '0;
    logic            coef_rd_o, var_rd_o, busy_o, done_o;
    logic [AW-1:0]   coef_addr_o, var_addr_o;
    logic [DW-1:0]   coef_data_i, var_data_i;
    logic [ACCW-1:0] result_o;

    logic signed [DW-1:0] rom [MSZ];
    logic signed [DW-1:0] ram [MSZ];

    exp_t   sbq[$];
    int     tests = 0;
    int     fails = 0;
    longint cyc = 0;
    int     reads = 0;
    logic [AW-1:0] cur_cb = '0;
    logic [AW-1:0] cur_vb = '0;
    bit     ended = 1'b0;

    always #10 clk = ~clk;

    dotp_engine u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .cbase_i(cbase_i), .vbase_i(vbase_i), .len_i(len_i),
        .coef_rd_o(coef_rd_o), .coef_addr_o(coef_addr_o), .coef_data_i(coef_data_i),
        .var_rd_o(var_rd_o), .var_addr_o(var_addr_o), .var_data_i(var_data_i),
        .busy_o(busy_o), .done_o(done_o), .result_o(result_o)
    );

    // Synchronous memory models, one-cycle latency
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (coef_rd_o) coef_data_i <= rom[coef_addr_o];
        if (var_rd_o)  var_data_i  <= ram[var_addr_o];
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    // Driver: queues the expected outcome, then issues the command
    task automatic run_op(input int cb, input int vb, input int n, input string tag);
        exp_t e;
        longint s = 0;
        while (busy_o) @(negedge clk);
        for (int i = 0; i < n; i++) begin
            s += longint'(rom[(cb + i) % MSZ]) * longint'(ram[(vb + i) % MSZ]);
        end
        e.sum = s;
        e.n   = n;
        e.tag = tag;
        e.cyc = cyc + 1 + ((n == 0) ? 1 : n + 1);
        sbq.push_back(e);
        cur_cb  = AW'(cb);
        cur_vb  = AW'(vb);
        start_i = 1'b1;
        cbase_i = AW'(cb);
        vbase_i = AW'(vb);
        len_i   = LW'(n);
        @(negedge clk);
        start_i = 1'b0;
    endtask

    // Start while busy: nothing is queued, it must change nothing
    task automatic poke_start(input int cb, input int vb, input int n);
        start_i = 1'b1;
        cbase_i = AW'(cb);
        vbase_i = AW'(vb);
        len_i   = LW'(n);
        @(negedge clk);
        start_i = 1'b0;
    endtask

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (coef_rd_o) begin
                check(var_rd_o, "R3", "var strobe with coef strobe", longint'(var_rd_o), 1);
                check(coef_addr_o == cur_cb + AW'(reads), "R3", "coef addr",
                      longint'(coef_addr_o), longint'(cur_cb + AW'(reads)));
                check(var_addr_o == cur_vb + AW'(reads), "R3", "var addr",
                      longint'(var_addr_o), longint'(cur_vb + AW'(reads)));
                reads++;
            end
            if (done_o) begin
                if (sbq.size() == 0) begin
                    check(1'b0, "R5", "done with empty scoreboard", 1, 0);
                end else begin
                    exp_t e;
                    longint act;
                    e = sbq.pop_front();
                    act = $signed(result_o);
                    check(act == e.sum, e.tag, "result (R4)", act, e.sum);
                    check(cyc == e.cyc, e.tag, "done cycle (R5)", cyc, e.cyc);
                    check(reads == e.n, e.tag, "read count (R3)", reads, e.n);
                    check(!busy_o, e.tag, "busy low in done cycle (R2)", longint'(busy_o), 0);
                end
                reads = 0;
            end
        end
    end

    // Watchdog
    always @(posedge clk) begin
        if (cyc > 100000) begin
            fails++;
            tests++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        for (int i = 0; i < MSZ; i++) begin
            if (i >= 512 && i < 768) begin
                rom[i] = -16'sd32768;
                ram[i] = -16'sd32768;
            end else begin
                rom[i] = DW'(((i * 73 + 11) % 4001) - 2000);
                ram[i] = DW'(((i * 151 + 3) % 60001) - 30000);
            end
        end
        repeat (3) @(negedge clk);
        // R1: reset state
        check(!busy_o && !done_o && !coef_rd_o && !var_rd_o && result_o == '0,
              "R1", "reset outputs", longint'({busy_o, done_o, coef_rd_o}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy_o && result_o == '0, "R1", "idle after reset", longint'(busy_o), 0);

        run_op(3, 7, 1, "R4");
        run_op(20, 100, 8, "R4");
        run_op(40, 40, 0, "R6");
        while (busy_o) @(negedge clk);
        @(negedge clk);
        check(result_o == '0 && !done_o, "R6", "zero result held", longint'(result_o), 0);

        run_op(1020, 1015, 10, "R3");   // address wrap
        run_op(512, 512, 256, "R9");    // extreme magnitude

        // R8: second start lands in the done cycle
        run_op(60, 300, 5, "R8");
        run_op(200, 900, 3, "R8");

        // R7: starts while busy are ignored
        run_op(100, 400, 20, "R7");
        repeat (4) @(negedge clk);
        poke_start(0, 0, 2);
        repeat (3) @(negedge clk);
        poke_start(5, 6, 0);
        while (busy_o || sbq.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
        // R5: result held after done, no stray done
        check(!done_o && !busy_o, "R5", "quiet after run", longint'(done_o), 0);
        begin
            longint s = 0;
            for (int i = 0; i < 20; i++) s += longint'(rom[100 + i]) * longint'(ram[400 + i]);
            check(longint'($signed(result_o)) == s, "R5", "result held",
                  longint'($signed(result_o)), s);
        end
        check(sbq.size() == 0, "R7", "scoreboard drained", sbq.size(), 0);
        finish_run();
    end

endmodule